// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Detector

This block lives inside an I2C target and decides which speed regime the bus is in. It takes the raw SCL and SDA lines, sampled by a much faster system clock, passes them through a two-flop synchronizer and a digital spike filter, and turns them into bus conditions. A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high.

After every start or repeated start, the first byte is examined. If its upper five bits are `00001`, it is the high-speed master code, and the low three bits can take any value. The master code arrives at standard/fast speed and is never acknowledged. The block raises an ACK-block level so that the target's ACK driver keeps SDA released for the ninth clock. It also raises a sticky high-speed flag. Repeated starts keep the flag set, and only a stop clears it. The flag selects the spike-filter length: a long filter in standard/fast mode and a short one in high-speed mode. The filter length is also provided as an output so that other input stages can use the same setting.

The byte tracker is a five-state machine:
- `ST_IDLE`: the bus is free.
- `ST_FIRST`: the first byte after a start is being shifted in.
- `ST_CODE_ACK`: the unacknowledged ninth clock of the master code.
- `ST_WAIT_RS`: high-speed mode is armed and the block waits for the repeated start.
- `ST_BODY`: an ordinary transfer is in progress, and every byte is treated as data.

The transitions are:
- A stop takes any state to `ST_IDLE`.
- A start or repeated start takes any state to `ST_FIRST`.
- `ST_FIRST` goes to `ST_CODE_ACK` on the eighth SCL rise if the byte matches the master code, and to `ST_BODY` otherwise.
- `ST_CODE_ACK` goes to `ST_WAIT_RS` on the SCL fall that ends the ninth clock.

Top module: `hs_mode_detector`

## Requirements
- R1: After reset, `hs_mode_o` is 0, `filt_len_o` equals FLT_LONG (4), `ack_block_o` is 0, and no event pulse is active.
- R2: `start_o` pulses for exactly one cycle for each SDA fall while SCL is high. `stop_o` pulses for exactly one cycle for each SDA rise while SCL is high. A change on SDA while SCL is low produces no pulse.
- R3: When the first byte after a start or repeated start has bits [7:3] equal to `00001`, `code_seen_o` pulses once on its eighth SCL rise and `hs_mode_o` becomes 1. Bits [2:0] of that byte are ignored.
- R4: For a recognised master code, `ack_block_o` is 1 from the eighth SCL rise until the SCL fall that ends the ninth clock, and 0 afterwards.
- R5: A first byte whose bits [7:3] differ from `00001` gives no `code_seen_o`, no `ack_block_o`, and leaves `hs_mode_o` unchanged.
- R6: A byte matching the master-code pattern in any position other than the first byte after a start is treated as data: no `code_seen_o`, and no change to the mode.
- R7: Once set, `hs_mode_o` stays 1 across any number of repeated starts.
- R8: A stop clears `hs_mode_o` to 0. This includes a stop in the middle of a byte and a stop during the ninth clock of the master code, which also drops `ack_block_o`.
- R9: `filt_len_o` is FLT_SHORT (2) while `hs_mode_o` is 1 and FLT_LONG (4) while it is 0. The spike filter on both lines uses this length.
- R10: A pulse on SDA shorter than the active filter length (3 samples in standard/fast mode, 1 sample in high-speed mode) produces no start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| hs_mode_o | output | 1 | 1 while the bus is in high-speed mode |
| filt_len_o | output | FLT_W | Active spike-filter length in samples |
| code_seen_o | output | 1 | One-cycle pulse when a master code is recognised |
| ack_block_o | output | 1 | Hold SDA released, covering the master code's ninth clock |
| start_o | output | 1 | One-cycle pulse for a start or repeated start |
| stop_o | output | 1 | One-cycle pulse for a stop |

## Verification
Two functions can land in the same cycle. A stop can arrive while the master code's ninth clock is still in progress, so the stop path clearing the mode flag collides with the byte tracker that holds `ST_CODE_ACK`. The bench provokes this by sending a master code, holding SDA low during the ninth SCL high phase, and then raising it. It expects a `stop_o` event on the scoreboard, and then expects both `ack_block_o` and `hs_mode_o` at 0 with the filter length back at the long value. A second overlap is tested too: while the short filter is active, a one-sample SDA dip during SCL high must yield no event.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    localparam int BYTE_BITS     = 8;
    localparam int BIT_CNT_W     = 4;
    localparam int CODE_PREFIX_W = 5;
    localparam logic [CODE_PREFIX_W-1:0] CODE_PREFIX = 5'b00001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_CODE_ACK,
        ST_WAIT_RS,
        ST_BODY
    } hsd_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/hsd_sync.sv
module hsd_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], d_i[b]};
            end
        end

        assign q_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/hsd_spike_filter.sv
module hsd_spike_filter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             out_o
);

    logic [CNT_W-1:0] run_q;
    logic             out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            out_q <= 1'b1;
        end else if (in_i == out_q) begin
            run_q <= '0;
        end else if (run_q >= lim_i - CNT_W'(1)) begin
            out_q <= in_i;
            run_q <= '0;
        end else begin
            run_q <= run_q + CNT_W'(1);
        end
    end

    assign out_o = out_q;

    // R10: the output only ever moves to a level the input already held
    assert_follow_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> (out_q == $past(in_i)));

endmodule

// File: rtl/hsd_cond_detect.sv
module hsd_cond_detect
    import hsd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic     scl_p_q, sda_p_q;
    bus_evt_t evt_d, evt_q;

    always_comb begin
        evt_d          = '0;
        evt_d.start    = scl_i && scl_p_q && sda_p_q && !sda_i;
        evt_d.stop     = scl_i && scl_p_q && !sda_p_q && sda_i;
        evt_d.scl_rise = scl_i && !scl_p_q;
        evt_d.scl_fall = !scl_i && scl_p_q;
        evt_d.sda      = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
            evt_q   <= '0;
        end else begin
            scl_p_q <= scl_i;
            sda_p_q <= sda_i;
            evt_q   <= evt_d;
        end
    end

    assign evt_o = evt_q;

endmodule

// File: rtl/hsd_byte_fsm.sv
module hsd_byte_fsm
    import hsd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_evt_t evt_i,
    output logic     code_seen_o,
    output logic     ack_block_o
);

    hsd_state_e           state_q, state_d;
    logic [BIT_CNT_W-1:0] bits_q;
    logic [BYTE_BITS-2:0] shift_q;
    logic [BYTE_BITS-1:0] byte_w;
    logic                 last_bit;
    logic                 is_code;

    assign byte_w   = {shift_q, evt_i.sda};
    assign last_bit = evt_i.scl_rise && (bits_q == BIT_CNT_W'(BYTE_BITS - 1));
    assign is_code  = (byte_w[BYTE_BITS-1 -: CODE_PREFIX_W] == CODE_PREFIX);

    always_comb begin
        state_d = state_q;
        if (evt_i.stop) begin
            state_d = ST_IDLE;
        end else if (evt_i.start) begin
            state_d = ST_FIRST;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_FIRST:    if (last_bit) state_d = is_code ? ST_CODE_ACK : ST_BODY;
                ST_CODE_ACK: if (evt_i.scl_fall && bits_q == BIT_CNT_W'(BYTE_BITS + 1))
                                 state_d = ST_WAIT_RS;
                ST_WAIT_RS:  state_d = ST_WAIT_RS;
                ST_BODY:     state_d = ST_BODY;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register with bit counter and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            if (evt_i.start || evt_i.stop) begin
                bits_q <= '0;
            end else if (evt_i.scl_rise &&
                         (state_q == ST_FIRST || state_q == ST_CODE_ACK)) begin
                bits_q  <= bits_q + BIT_CNT_W'(1);
                shift_q <= byte_w[BYTE_BITS-2:0];
            end
        end
    end

    // outputs
    always_comb begin
        code_seen_o = 1'b0;
        ack_block_o = 1'b0;
        unique case (state_q)
            ST_FIRST:    code_seen_o = last_bit && is_code && !evt_i.start && !evt_i.stop;
            ST_CODE_ACK: ack_block_o = 1'b1;
            default:     ;
        endcase
    end

    // R4: ACK blocking starts only right after a master code was recognised
    assert_ack_after_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_block_o && !$past(ack_block_o)) |-> $past(code_seen_o));

    // R2: start and stop cannot both be decoded in one sample
    assert_single_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_i.start && evt_i.stop));

endmodule

// File: rtl/hsd_mode_flag.sv
module hsd_mode_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic hs_o
);

    logic hs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
        end else if (clr_i) begin
            hs_q <= 1'b0;
        end else if (set_i) begin
            hs_q <= 1'b1;
        end
    end

    assign hs_o = hs_q;

endmodule

// File: rtl/hs_mode_detector.sv
module hs_mode_detector
    import hsd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FLT_LONG    = 4,
    parameter int FLT_SHORT   = 2,
    localparam int FLT_MAX    = (FLT_LONG > FLT_SHORT) ? FLT_LONG : FLT_SHORT,
    localparam int FLT_W      = $clog2(FLT_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             hs_mode_o,
    output logic [FLT_W-1:0] filt_len_o,
    output logic             code_seen_o,
    output logic             ack_block_o,
    output logic             start_o,
    output logic             stop_o
);

    logic [1:0]       raw_sync;
    logic [1:0]       filt;
    logic [FLT_W-1:0] lim;
    bus_evt_t         evt;
    logic             hs;
    logic             code_seen;
    logic             ack_block;

    hsd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sda_i, scl_i}),
        .q_o   (raw_sync)
    );

    assign lim = hs ? FLT_W'(FLT_SHORT) : FLT_W'(FLT_LONG);

    for (genvar l = 0; l < 2; l++) begin : g_flt
        hsd_spike_filter #(.CNT_W(FLT_W)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (raw_sync[l]),
            .lim_i (lim),
            .out_o (filt[l])
        );
    end

    hsd_cond_detect u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (filt[0]),
        .sda_i (filt[1]),
        .evt_o (evt)
    );

    hsd_byte_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .code_seen_o (code_seen),
        .ack_block_o (ack_block)
    );

    hsd_mode_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (code_seen),
        .clr_i (evt.stop),
        .hs_o  (hs)
    );

    assign hs_mode_o   = hs;
    assign filt_len_o  = lim;
    assign code_seen_o = code_seen;
    assign ack_block_o = ack_block;
    assign start_o     = evt.start;
    assign stop_o      = evt.stop;

    // R3: high-speed mode is entered only through a recognised master code
    assert_enter_by_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !$past(hs)) |-> $past(code_seen));

    // R8: high-speed mode is left only through a stop
    assert_leave_by_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs && $past(hs)) |-> $past(evt.stop));

    // R8: a stop always lands in standard/fast mode
    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> !hs);

    // R4: a held ACK block implies the mode flag is already set
    assert_block_in_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_block && $past(ack_block)) |-> hs);

endmodule

// File: tb/hs_mode_detector_bench.sv
module hs_mode_detector_bench;

    localparam int H = 16;
    localparam int Q = 8;
    localparam int EV_START = 0;
    localparam int EV_STOP  = 1;
    localparam int EV_CODE  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       hs_mode_o, code_seen_o, ack_block_o, start_o, stop_o;
    logic [2:0] filt_len_o;

    int n_checks = 0;
    int n_errors = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hs_mode_detector u_hs_mode_detector (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda),
        .hs_mode_o   (hs_mode_o),
        .filt_len_o  (filt_len_o),
        .code_seen_o (code_seen_o),
        .ack_block_o (ack_block_o),
        .start_o     (start_o),
        .stop_o      (stop_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pop_cmp(input int kind);
        if (exp_q.size() == 0) begin
            check(1'b0, "R2/R3 unexpected event", kind, -1);
        end else begin
            int e;
            e = exp_q.pop_front();
            check(e == kind, "R2/R3 event order", kind, e);
        end
    endtask

    // monitor: pops the scoreboard as events appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_o)     pop_cmp(EV_START);
            if (stop_o)      pop_cmp(EV_STOP);
            if (code_seen_o) pop_cmp(EV_CODE);
        end
    end

    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        exp_q.push_back(EV_START);
        sda = 1'b1; wcyc(H);
        scl = 1'b1; wcyc(H);
        sda = 1'b0; wcyc(H);
        scl = 1'b0; wcyc(Q);
    endtask

    task automatic bus_stop();
        wcyc(Q); sda = 1'b0;
        wcyc(Q); scl = 1'b1;
        wcyc(H);
        exp_q.push_back(EV_STOP);
        sda = 1'b1;
        wcyc(H);
    endtask

    task automatic send_bit(input logic b);
        wcyc(Q); sda = b;
        wcyc(Q); scl = 1'b1;
        wcyc(H); scl = 1'b0;
    endtask

    // ninth clock: the master releases SDA unless it closes with a stop
    task automatic send_byte(input logic [7:0] v, input bit code, input bit stop9);
        for (int i = 7; i >= 0; i--) begin
            if (i == 0 && code) exp_q.push_back(EV_CODE);
            send_bit(v[i]);
        end
        wcyc(Q); sda = stop9 ? 1'b0 : 1'b1;
        wcyc(Q); scl = 1'b1;
        wcyc(Q);
        check(ack_block_o == code, "R4/R5 ack block in ninth clock", ack_block_o, code);
        if (stop9) begin
            exp_q.push_back(EV_STOP);
            sda = 1'b1;
            wcyc(H + 20);
        end else begin
            wcyc(Q); scl = 1'b0;
            wcyc(20);
            check(ack_block_o == 1'b0, "R4 ack block released", ack_block_o, 0);
        end
    endtask

    task automatic mode_check(input bit exp_hs, input string tag);
        check(hs_mode_o == exp_hs, tag, hs_mode_o, exp_hs);
        check(filt_len_o == (exp_hs ? 3'd2 : 3'd4), "R9 filter length", filt_len_o,
              exp_hs ? 2 : 4);
    endtask

    initial begin
        wcyc(5);
        check(hs_mode_o == 1'b0, "R1 reset mode", hs_mode_o, 0);
        check(filt_len_o == 3'd4, "R1 reset filter", filt_len_o, 4);
        check(ack_block_o == 1'b0, "R1 reset ack block", ack_block_o, 0);
        check(!start_o && !stop_o && !code_seen_o, "R1 reset pulses", start_o, 0);
        rst_n = 1'b1;
        wcyc(10);

        // R10: 3-sample SDA dip with SCL high, long filter active
        sda = 1'b0; wcyc(3); sda = 1'b1; wcyc(30);
        check(exp_q.size() == 0, "R10 fs glitch no event", exp_q.size(), 0);

        // R5 and R6: ordinary first byte, then a code pattern as data
        bus_start();
        send_byte(8'h50, 1'b0, 1'b0);
        mode_check(1'b0, "R5 no mode change");
        send_byte(8'h0A, 1'b0, 1'b0);
        mode_check(1'b0, "R6 code as data ignored");
        bus_stop();
        wcyc(20);

        // R3, R4, R7: master code, repeated starts keep high-speed mode
        bus_start();
        send_byte(8'h08, 1'b1, 1'b0);
        mode_check(1'b1, "R3 mode after code");
        bus_start();
        send_byte(8'hA0, 1'b0, 1'b0);
        mode_check(1'b1, "R7 held after repeated start");
        bus_start();
        mode_check(1'b1, "R7 held after second repeated start");
        send_byte(8'h3C, 1'b0, 1'b0);
        // R10: 1-sample SDA dip with SCL high, short filter active
        wcyc(Q); sda = 1'b1;
        wcyc(Q); scl = 1'b1;
        wcyc(6); sda = 1'b0; wcyc(1); sda = 1'b1;
        wcyc(H); scl = 1'b0; wcyc(20);
        check(exp_q.size() == 0, "R10 hs glitch no event", exp_q.size(), 0);
        mode_check(1'b1, "R10 mode kept after glitch");
        bus_stop();
        wcyc(20);
        mode_check(1'b0, "R8 stop clears");

        // R3 don't-care low bits, R8 stop in mid-byte
        bus_start();
        send_byte(8'h0F, 1'b1, 1'b0);
        mode_check(1'b1, "R3 low bits ignored");
        bus_start();
        send_byte(8'h0C, 1'b1, 1'b0);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        wcyc(20);
        mode_check(1'b0, "R8 stop mid byte");

        // R8 concurrency: stop during the master code's ninth clock
        bus_start();
        send_byte(8'h09, 1'b1, 1'b1);
        check(ack_block_o == 1'b0, "R8 ack block dropped by stop", ack_block_o, 0);
        mode_check(1'b0, "R8 stop in ninth clock");

        // normal entry still works afterwards
        bus_start();
        send_byte(8'h0B, 1'b1, 1'b0);
        mode_check(1'b1, "R3 re-entry");
        bus_stop();
        wcyc(20);
        mode_check(1'b0, "R8 final stop");

        check(exp_q.size() == 0, "R2 all events seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule